// File: doc/BRIEF.md
# Machine-Mode Control Register File with 64-bit Event Counters

This block holds the machine-level control and status registers of a small 32-bit processor core: the status word, the interrupt-enable word, the trap vector base, a scratch word, the exception return address, the trap cause and the counter-inhibit bits. It also keeps two 64-bit event counters, one for cycles and one for retired steps. Each counter is reachable as a low and a high 32-bit half. A set of fixed identification words reads back as constants, and some of those come from module parameters.

The core drives one access per cycle. An access carries an address, an operation code, write data and the current privilege level. The read data and a fault flag come back in the same cycle. A write, set or clear takes effect at the next rising clock edge. Set and clear are read-modify-write operations that work on the value the register reads at that moment. Both counters advance on every clock unless their inhibit bit is set. A software write to one half of a counter lands after that cycle's increment, so the other half still takes its incremented value.

Top module: `mcsr_file`

## Requirements
- R1: `acc_fault` is 1 for an enabled access when any of three conditions holds: the address is 4096 or above, address bits 9:8 exceed `cur_priv`, or the address is not one of those listed in R8 and R10. A faulted access reads 0.
- R2: A faulted write, set or clear changes no register.
- R3: `acc_op` encodes the operation as 0 = read, 1 = write data, 2 = set (old | data), 3 = clear (old & ~data). Read data is valid in the same cycle. A write is visible from the next rising edge.
- R4: The counter-inhibit register (0x320) keeps only bits 2:0 and reads 0 above them. Bit 0 freezes the cycle counter and bit 2 freezes the step counter.
- R5: The cycle counter (low 0xB00, high 0xB80) and the step counter (low 0xB02, high 0xB82) each add one per clock as a single 64-bit value, so a carry passes from the low half into the high half.
- R6: In a cycle where a counter half is written, the written half takes the new data and the other half takes the value after that cycle's increment.
- R7: Write masks apply as follows. Trap vector (0x305) bit 1 always reads 0. Return address (0x341) bit 0 always reads 0. Cause (0x342) keeps only bit 31 and bits 3:0.
- R8: The constant words read as follows: ISA word (0x301) reads 0x40901105, trap value (0x343) reads 0 and pending-interrupt word (0x344) reads 0. Vendor (0xF11), architecture (0xF12), implementation (0xF13), hart (0xF14) and configuration pointer (0xF15) read their parameter values.
- R9: A write, set or clear to any R8 address raises no fault and leaves its read value unchanged.
- R10: Status (0x300), interrupt enable (0x304) and scratch (0x340) store all 32 bits. All registers in this block reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Register address |
| acc_op | input | 2 | Operation: 0 read, 1 write, 2 set, 3 clear |
| acc_wdata | input | 32 | Write data or bit mask |
| cur_priv | input | 2 | Current privilege level (3 = machine) |
| rd_data | output | 32 | Read data, 0 on a fault |
| acc_fault | output | 1 | The access is refused |

## Verification
The bench aims at the ordering of a half write against the increment. It writes the high cycle half on the exact edge where the low half wraps, and expects the low half to read 1 and the high half to read the written value. A design that held the unwritten half would show the low half frozen and the high half one too large. Carry is checked by releasing a frozen counter at 0x0_FFFFFFFF: a design that treats the halves as separate 32-bit counters never reads 1 in the high half. The bench also checks faults from the address-range, privilege and decode conditions, and confirms through a read-back that a refused write left the scratch word intact. It covers set and clear on masked registers, and writes to constants that must neither fault nor stick.

// File: rtl/mcsr_file_pkg.sv
package mcsr_file_pkg;

   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_SET   = 2'd2,
      OP_CLEAR = 2'd3
   } csr_op_e;

   typedef enum logic [4:0] {
      SEL_NONE, SEL_STATUS, SEL_ISA, SEL_IEN, SEL_TVEC, SEL_INHIBIT,
      SEL_SCRATCH, SEL_EPC, SEL_CAUSE, SEL_TVAL, SEL_PEND,
      SEL_CYC_LO, SEL_CYC_HI, SEL_STP_LO, SEL_STP_HI,
      SEL_VENDOR, SEL_ARCH, SEL_IMPL, SEL_HART, SEL_CFGPTR
   } csr_sel_e;

   localparam logic [11:0] A_STATUS  = 12'h300;
   localparam logic [11:0] A_ISA     = 12'h301;
   localparam logic [11:0] A_IEN     = 12'h304;
   localparam logic [11:0] A_TVEC    = 12'h305;
   localparam logic [11:0] A_INHIBIT = 12'h320;
   localparam logic [11:0] A_SCRATCH = 12'h340;
   localparam logic [11:0] A_EPC     = 12'h341;
   localparam logic [11:0] A_CAUSE   = 12'h342;
   localparam logic [11:0] A_TVAL    = 12'h343;
   localparam logic [11:0] A_PEND    = 12'h344;
   localparam logic [11:0] A_CYC_LO  = 12'hB00;
   localparam logic [11:0] A_STP_LO  = 12'hB02;
   localparam logic [11:0] A_CYC_HI  = 12'hB80;
   localparam logic [11:0] A_STP_HI  = 12'hB82;
   localparam logic [11:0] A_VENDOR  = 12'hF11;
   localparam logic [11:0] A_ARCH    = 12'hF12;
   localparam logic [11:0] A_IMPL    = 12'hF13;
   localparam logic [11:0] A_HART    = 12'hF14;
   localparam logic [11:0] A_CFGPTR  = 12'hF15;

   localparam logic [31:0] ISA_WORD   = 32'h4090_1105;
   localparam logic [31:0] TVEC_KEEP  = 32'hFFFF_FFFD;
   localparam logic [31:0] EPC_KEEP   = 32'hFFFF_FFFE;
   localparam logic [31:0] CAUSE_KEEP = 32'h8000_000F;

endpackage

// File: rtl/mcsr_addr_dec.sv
module mcsr_addr_dec
   import mcsr_file_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [1:0]         priv,
   output csr_sel_e           sel,
   output logic               fault
);

   logic out_of_range;
   logic [11:0] a12;

   assign a12 = addr[11:0];

   generate
      if (ADDR_W > 12) begin : g_wide
         assign out_of_range = |addr[ADDR_W-1:12];
      end else begin : g_narrow
         assign out_of_range = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (a12)
         A_STATUS:  sel = SEL_STATUS;
         A_ISA:     sel = SEL_ISA;
         A_IEN:     sel = SEL_IEN;
         A_TVEC:    sel = SEL_TVEC;
         A_INHIBIT: sel = SEL_INHIBIT;
         A_SCRATCH: sel = SEL_SCRATCH;
         A_EPC:     sel = SEL_EPC;
         A_CAUSE:   sel = SEL_CAUSE;
         A_TVAL:    sel = SEL_TVAL;
         A_PEND:    sel = SEL_PEND;
         A_CYC_LO:  sel = SEL_CYC_LO;
         A_CYC_HI:  sel = SEL_CYC_HI;
         A_STP_LO:  sel = SEL_STP_LO;
         A_STP_HI:  sel = SEL_STP_HI;
         A_VENDOR:  sel = SEL_VENDOR;
         A_ARCH:    sel = SEL_ARCH;
         A_IMPL:    sel = SEL_IMPL;
         A_HART:    sel = SEL_HART;
         A_CFGPTR:  sel = SEL_CFGPTR;
         default:   sel = SEL_NONE;
      endcase
   end

   assign fault = out_of_range || (a12[9:8] > priv) || (sel == SEL_NONE);

   // R1: privilege above the caller always refuses the access
   always_comb begin
      if (a12[9:8] > priv) begin
         p_priv_fault_r1: assert (fault);
      end
   end

endmodule

// File: rtl/mcsr_counter64.sv
module mcsr_counter64 #(
   parameter int HALF_W = 32,
   localparam int CNT_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inhibit,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [HALF_W-1:0] wdata,
   output logic [CNT_W-1:0]  value
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] bumped;

   // Increment first as one wide value; the software write overrides after
   assign bumped = inhibit ? cnt_q : cnt_q + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         cnt_q[HALF_W-1:0]     <= wr_lo ? wdata : bumped[HALF_W-1:0];
         cnt_q[CNT_W-1:HALF_W] <= wr_hi ? wdata : bumped[CNT_W-1:HALF_W];
      end
   end

   assign value = cnt_q;

   p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!inhibit && !wr_lo && !wr_hi) |=> value == $past(value) + CNT_W'(1));

   p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (inhibit && !wr_lo && !wr_hi) |=> $stable(value));

   p_half_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && !wr_lo && !inhibit) |=>
         value[HALF_W-1:0] == $past(value[HALF_W-1:0]) + HALF_W'(1));

endmodule

// File: rtl/mcsr_file.sv
module mcsr_file
   import mcsr_file_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          XLEN      = 32,
   parameter logic [31:0] VENDOR_ID = 32'h0,
   parameter logic [31:0] ARCH_ID   = 32'h0,
   parameter logic [31:0] IMPL_ID   = 32'h0,
   parameter logic [31:0] HART_ID   = 32'h0,
   parameter logic [31:0] CFG_PTR   = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [1:0]        acc_op,
   input  logic [31:0]       acc_wdata,
   input  logic [1:0]        cur_priv,
   output logic [31:0]       rd_data,
   output logic              acc_fault
);

   localparam int NCNT  = 2;
   localparam int INH_W = 3;

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("mcsr_file supports XLEN of 32 only");
      end
      if (ADDR_W < 12) begin : g_bad_addr
         $error("mcsr_file needs ADDR_W of at least 12");
      end
   endgenerate

   csr_sel_e    sel;
   logic        dec_fault;
   logic [31:0] rd_mux;
   logic [31:0] wr_val;
   logic        wr_go;

   logic [31:0] status_q, ien_q, tvec_q, scratch_q, epc_q, cause_q;
   logic [INH_W-1:0] inh_q;
   logic [63:0] cnt_val [NCNT];

   mcsr_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr  (acc_addr),
      .priv  (cur_priv),
      .sel   (sel),
      .fault (dec_fault)
   );

   always_comb begin
      unique case (sel)
         SEL_STATUS:  rd_mux = status_q;
         SEL_ISA:     rd_mux = ISA_WORD;
         SEL_IEN:     rd_mux = ien_q;
         SEL_TVEC:    rd_mux = tvec_q;
         SEL_INHIBIT: rd_mux = {{(32-INH_W){1'b0}}, inh_q};
         SEL_SCRATCH: rd_mux = scratch_q;
         SEL_EPC:     rd_mux = epc_q;
         SEL_CAUSE:   rd_mux = cause_q;
         SEL_CYC_LO:  rd_mux = cnt_val[0][31:0];
         SEL_CYC_HI:  rd_mux = cnt_val[0][63:32];
         SEL_STP_LO:  rd_mux = cnt_val[1][31:0];
         SEL_STP_HI:  rd_mux = cnt_val[1][63:32];
         SEL_VENDOR:  rd_mux = VENDOR_ID;
         SEL_ARCH:    rd_mux = ARCH_ID;
         SEL_IMPL:    rd_mux = IMPL_ID;
         SEL_HART:    rd_mux = HART_ID;
         SEL_CFGPTR:  rd_mux = CFG_PTR;
         default:     rd_mux = 32'h0;
      endcase
   end

   assign rd_data   = dec_fault ? 32'h0 : rd_mux;
   assign acc_fault = acc_en && dec_fault;

   always_comb begin
      unique case (csr_op_e'(acc_op))
         OP_SET:   wr_val = rd_mux | acc_wdata;
         OP_CLEAR: wr_val = rd_mux & ~acc_wdata;
         default:  wr_val = acc_wdata;
      endcase
   end

   assign wr_go = acc_en && (acc_op != OP_READ) && !dec_fault;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q  <= '0;
         ien_q     <= '0;
         tvec_q    <= '0;
         scratch_q <= '0;
         epc_q     <= '0;
         cause_q   <= '0;
         inh_q     <= '0;
      end else if (wr_go) begin
         unique case (sel)
            SEL_STATUS:  status_q  <= wr_val;
            SEL_IEN:     ien_q     <= wr_val;
            SEL_TVEC:    tvec_q    <= wr_val & TVEC_KEEP;
            SEL_SCRATCH: scratch_q <= wr_val;
            SEL_EPC:     epc_q     <= wr_val & EPC_KEEP;
            SEL_CAUSE:   cause_q   <= wr_val & CAUSE_KEEP;
            SEL_INHIBIT: inh_q     <= wr_val[INH_W-1:0];
            default: ;
         endcase
      end
   end

   genvar g;
   generate
      for (g = 0; g < NCNT; g++) begin : g_cnt
         localparam csr_sel_e LO_SEL = (g == 0) ? SEL_CYC_LO : SEL_STP_LO;
         localparam csr_sel_e HI_SEL = (g == 0) ? SEL_CYC_HI : SEL_STP_HI;
         mcsr_counter64 #(.HALF_W(32)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inhibit (inh_q[2*g]),
            .wr_lo   (wr_go && (sel == LO_SEL)),
            .wr_hi   (wr_go && (sel == HI_SEL)),
            .wdata   (wr_val),
            .value   (cnt_val[g])
         );
      end
   endgenerate

   p_fault_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_fault && acc_op != 2'd0) |=>
         ($stable(scratch_q) && $stable(status_q) && $stable(ien_q)));

   p_cause_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_q & ~CAUSE_KEEP) == 32'h0);

   p_tvec_epc_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tvec_q[1] == 1'b0) && (epc_q[0] == 1'b0));

   p_fault_reads_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      acc_fault |-> rd_data == 32'h0);

endmodule

// File: tb/mcsr_file_test.sv
module mcsr_file_test;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] VID = 32'h1357_2468;
   localparam logic [31:0] AID = 32'h0000_0042;
   localparam logic [31:0] IID = 32'h0000_0103;
   localparam logic [31:0] CPT = 32'h0000_1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_en = 1'b0;
   logic [15:0] acc_addr = '0;
   logic [1:0]  acc_op = '0;
   logic [31:0] acc_wdata = '0;
   logic [1:0]  cur_priv = 2'd3;
   logic [31:0] rd_data;
   logic        acc_fault;

   int n_tests = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mcsr_file #(
      .ADDR_W(16), .XLEN(32), .VENDOR_ID(VID), .ARCH_ID(AID),
      .IMPL_ID(IID), .HART_ID(32'h0), .CFG_PTR(CPT)
   ) uut (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_addr(acc_addr),
      .acc_op(acc_op), .acc_wdata(acc_wdata), .cur_priv(cur_priv),
      .rd_data(rd_data), .acc_fault(acc_fault)
   );

   typedef struct packed {
      logic [15:0] addr;
      logic [1:0]  op;
      logic [31:0] data;
      logic [31:0] expect_rd;
      logic [7:0]  req;
   } vec_t;

   localparam int NVEC = 16;
   localparam vec_t VECS [NVEC] = '{
      '{16'h0340, 2'd1, 32'hDEADBEEF, 32'hDEADBEEF, 8'd10}, // R10 scratch
      '{16'h0340, 2'd2, 32'h00000010, 32'hDEADBEFF, 8'd3},  // R3 set
      '{16'h0340, 2'd3, 32'hFF000000, 32'h00ADBEFF, 8'd3},  // R3 clear
      '{16'h0300, 2'd1, 32'h12345678, 32'h12345678, 8'd10}, // R10 status
      '{16'h0304, 2'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'd10}, // R10 enable
      '{16'h0304, 2'd3, 32'h0000FFFF, 32'hFFFF0000, 8'd3},  // R3 clear
      '{16'h0305, 2'd1, 32'hFFFFFFFF, 32'hFFFFFFFD, 8'd7},  // R7 tvec
      '{16'h0341, 2'd1, 32'h00000013, 32'h00000012, 8'd7},  // R7 epc
      '{16'h0342, 2'd1, 32'hFFFFFFFF, 32'h8000000F, 8'd7},  // R7 cause
      '{16'h0342, 2'd2, 32'h00000070, 32'h8000000F, 8'd7},  // R7 set masked
      '{16'h0301, 2'd1, 32'h00000000, 32'h40901105, 8'd9},  // R9 isa
      '{16'h0343, 2'd1, 32'h0000FFFF, 32'h00000000, 8'd9},  // R9 tval
      '{16'h0344, 2'd2, 32'h0000FFFF, 32'h00000000, 8'd9},  // R9 pending
      '{16'h0F11, 2'd1, 32'h00000000, VID,          8'd9},  // R9 vendor
      '{16'h0F12, 2'd0, 32'h00000000, AID,          8'd8},  // R8 arch
      '{16'h0F15, 2'd3, 32'hFFFFFFFF, CPT,          8'd9}   // R9 cfg ptr
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_acc(input logic [15:0] a, input logic [1:0] op,
                         input logic [31:0] d, input logic [1:0] p,
                         output logic [31:0] rd, output logic flt);
      @(negedge clk);
      acc_en = 1'b1; acc_addr = a; acc_op = op; acc_wdata = d; cur_priv = p;
      #1;
      rd = rd_data;
      flt = acc_fault;
      @(negedge clk);
      acc_en = 1'b0; acc_op = 2'd0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog expired before the bench completed");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] r, r2;
      logic f;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset values
      do_acc(16'h0340, 2'd0, 0, 2'd3, r, f);
      check("R10 scratch reset", r, 32'h0);
      do_acc(16'h0320, 2'd0, 0, 2'd3, r, f);
      check("R10 inhibit reset", r, 32'h0);

      // R5 free-running counters: two clocks between consecutive samples
      do_acc(16'h0B00, 2'd0, 0, 2'd3, r, f);
      do_acc(16'h0B00, 2'd0, 0, 2'd3, r2, f);
      check("R5 cycle count step", r2 - r, 32'd2);
      do_acc(16'h0B02, 2'd0, 0, 2'd3, r, f);
      do_acc(16'h0B02, 2'd0, 0, 2'd3, r2, f);
      check("R5 step count step", r2 - r, 32'd2);

      // Vector table
      for (int i = 0; i < NVEC; i++) begin
         do_acc(VECS[i].addr, VECS[i].op, VECS[i].data, 2'd3, r, f);
         check($sformatf("R%0d row %0d fault", VECS[i].req, i), {31'b0, f}, 32'h0);
         do_acc(VECS[i].addr, 2'd0, 0, 2'd3, r, f);
         check($sformatf("R%0d row %0d readback", VECS[i].req, i), r, VECS[i].expect_rd);
      end
      do_acc(16'h0F14, 2'd0, 0, 2'd3, r, f);
      check("R8 hart id", r, 32'h0);

      // R1 faults
      do_acc(16'h1340, 2'd0, 0, 2'd3, r, f);
      check("R1 range fault", {31'b0, f}, 32'h1);
      check("R1 range fault reads zero", r, 32'h0);
      do_acc(16'h0340, 2'd0, 0, 2'd1, r, f);
      check("R1 privilege fault", {31'b0, f}, 32'h1);
      do_acc(16'h03A0, 2'd0, 0, 2'd3, r, f);
      check("R1 unimplemented fault", {31'b0, f}, 32'h1);
      do_acc(16'h0344, 2'd0, 0, 2'd3, r, f);
      check("R1 implemented no fault", {31'b0, f}, 32'h0);

      // R2 refused writes leave scratch untouched (holds 0x00ADBEFF)
      do_acc(16'h0340, 2'd1, 32'h11111111, 2'd0, r, f);
      check("R2 priv write faults", {31'b0, f}, 32'h1);
      do_acc(16'h1340, 2'd2, 32'hFFFFFFFF, 2'd3, r, f);
      do_acc(16'h0340, 2'd0, 0, 2'd3, r, f);
      check("R2 scratch unchanged", r, 32'h00ADBEFF);

      // R4 inhibit masking and freezing
      do_acc(16'h0320, 2'd1, 32'hFFFFFFFF, 2'd3, r, f);
      do_acc(16'h0320, 2'd0, 0, 2'd3, r, f);
      check("R4 inhibit keeps 2:0", r, 32'h7);
      do_acc(16'h0B00, 2'd0, 0, 2'd3, r, f);
      do_acc(16'h0B00, 2'd0, 0, 2'd3, r2, f);
      check("R4 cycle frozen", r2 - r, 32'd0);
      do_acc(16'h0320, 2'd1, 32'h1, 2'd3, r, f);
      do_acc(16'h0B02, 2'd0, 0, 2'd3, r, f);
      do_acc(16'h0B02, 2'd0, 0, 2'd3, r2, f);
      check("R4 step runs with bit2 clear", r2 - r, 32'd2);
      do_acc(16'h0B00, 2'd0, 0, 2'd3, r, f);
      do_acc(16'h0B00, 2'd0, 0, 2'd3, r2, f);
      check("R4 cycle frozen by bit0", r2 - r, 32'd0);

      // R5 carry from low into high half
      do_acc(16'h0320, 2'd1, 32'h5, 2'd3, r, f);
      do_acc(16'h0B00, 2'd1, 32'hFFFFFFFF, 2'd3, r, f);
      do_acc(16'h0B80, 2'd1, 32'h0, 2'd3, r, f);
      do_acc(16'h0320, 2'd3, 32'h1, 2'd3, r, f);
      do_acc(16'h0B80, 2'd0, 0, 2'd3, r, f);
      check("R5 carry into high", r, 32'h1);
      do_acc(16'h0B00, 2'd0, 0, 2'd3, r, f);
      check("R5 low after wrap", r, 32'h2);

      // R6 high write on the edge where the low half wraps
      do_acc(16'h0320, 2'd2, 32'h1, 2'd3, r, f);
      do_acc(16'h0B00, 2'd1, 32'hFFFFFFFE, 2'd3, r, f);
      do_acc(16'h0B80, 2'd1, 32'h7, 2'd3, r, f);
      do_acc(16'h0320, 2'd3, 32'h1, 2'd3, r, f);
      do_acc(16'h0B80, 2'd1, 32'h50, 2'd3, r, f);
      do_acc(16'h0B00, 2'd0, 0, 2'd3, r, f);
      check("R6 unwritten low took increment", r, 32'h1);
      do_acc(16'h0B80, 2'd0, 0, 2'd3, r, f);
      check("R6 written high kept data", r, 32'h50);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule